// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit stored-program processor. It holds the fetched opcode in an internal instruction register. At the decode step that opcode selects an entry in a jump-table ROM, and the entry is the start address of the instruction's microroutine. A micro-program counter then walks a microcode ROM. Every microword drives the datapath control word, the memory request and the read and write strobes, and it also says how the micro-program counter moves next.

Each microword carries a 2-bit sequencing field. The codes are:
- 00: advance by one.
- 01: dispatch through the jump table.
- 10: return to the common fetch routine at micro-address 0.
- 11: conditional branch. A 3-bit select picks the condition: codes 0 to 3 are flag bits 0 to 3, 4 is the memory-done strobe, 5 is its inverse, 6 is always true and 7 is never true.

Opcodes that have no microroutine go to a trap routine through the jump table. Both ROMs are constant arrays computed at elaboration.

Top module: `useq_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, the micro-program counter is 0. The outputs show the fetch word: ctrl 0x0005, mreq 1, rd 1, wr 0.
- R2: In the fetch word the sequencer stays on fetch while fetch_done is low. When fetch_done is high in the fetch word, the next cycle shows the decode word: ctrl 0x0000 with all strobes low.
- R3: The instruction register loads the opcode input only in a cycle whose word has ctrl bit 2 set and has fetch_done high. A change on the opcode input at any other time has no effect on the dispatch.
- R4: Dispatch maps these opcodes to microroutines: 0x00 NOP, 0x10 LDA, 0x20 ADD, 0x30 STA, 0x40 JZ. NOP is one word with ctrl 0x0000 followed by fetch.
- R5: The sequencing field codes are: 00 advance by one, 01 dispatch, 10 return to fetch, 11 conditional branch. A wait is built as a conditional branch to itself on the inverse of fetch_done.
- R6: ADD runs ctrl 0x0080 and then 0x0060 with no strobes, then returns to fetch.
- R7: LDA shows ctrl 0x0011 with mreq and rd for as long as fetch_done is low, and in the cycle fetch_done goes high. It then shows ctrl 0x0020, then returns to fetch.
- R8: STA shows ctrl 0x0008 with no strobes, then ctrl 0x0000 with mreq and wr high, then returns to fetch.
- R9: JZ shows ctrl 0x0000 in its test word. If flag bit 0 is high in that cycle, the next word is ctrl 0x0002. If it is low, the next word is ctrl 0x0100, whatever the other flag bits are. Either way the routine then returns to fetch.
- R10: Any other opcode runs the trap routine: ctrl 0x0200, then 0x0002, then fetch.
- R11: rd and wr are never high together, and neither is high without mreq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode byte from the memory data path |
| fetch_done | input | 1 | Memory transfer complete strobe |
| flags | input | 4 | ALU status flags, bit 0 is zero |
| ctrl | output | 16 | Datapath control word |
| mreq | output | 1 | Memory request |
| rd | output | 1 | Memory read strobe |
| wr | output | 1 | Memory write strobe |

## Verification
The outputs depend only on the micro-program counter. Inputs present in a cycle therefore decide which word appears one clock later. A dispatch shows the routine's first word two clocks after the cycle in which the fetch completes.

The bench drives inputs at the falling edge and queues the word expected for that same cycle. The monitor compares the outputs 1 ns after the same falling edge, so every comparison sees the outputs produced by the rising edge just before it. Each scripted step names the requirement it checks.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int OP_W = 8,
  parameter int UA_W = 10,
  parameter int CW_W = 16,
  parameter int FL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            fetch_done,
  input  logic [FL_W-1:0] flags,
  output logic [CW_W-1:0] ctrl,
  output logic            mreq,
  output logic            rd,
  output logic            wr
);
  localparam int UDEPTH = 1 << UA_W;
  localparam int JDEPTH = 1 << OP_W;
  localparam int MW_W   = CW_W + 3 + 2 + 3 + UA_W;

  localparam logic [1:0] SQ_INC = 2'd0, SQ_DISP = 2'd1, SQ_FETCH = 2'd2, SQ_COND = 2'd3;
  localparam logic [2:0] C_Z = 3'd0, C_FD = 3'd4, C_NFD = 3'd5, C_NEVER = 3'd7;

  localparam int B_PC_INC = 0, B_PC_LD = 1, B_IR_LD = 2, B_MAR_LD = 3, B_MDR_LD = 4;
  localparam int B_A_LD = 5, B_F_LD = 6, B_ALU_ADD = 7, B_PC_SKIP = 8, B_TRAP = 9;

  localparam int A_FETCH = 0, A_DEC = 1, A_NOP = 16, A_LDA = 32, A_ADD = 48;
  localparam int A_STA = 64, A_JZ = 80, A_TRAP = UDEPTH - 16;

  function automatic logic [CW_W-1:0] cb(input int b);
    cb = '0;
    cb[b] = 1'b1;
  endfunction

  function automatic logic [MW_W-1:0] pk(input logic [CW_W-1:0] c, input logic m, input logic r,
                                         input logic w, input logic [1:0] s, input logic [2:0] cs,
                                         input int t);
    pk = {c, m, r, w, s, cs, UA_W'(t)};
  endfunction

  function automatic logic [MW_W-1:0] ucode(input int a);
    case (a)
      A_FETCH:   ucode = pk(cb(B_IR_LD) | cb(B_PC_INC), 1'b1, 1'b1, 1'b0, SQ_COND, C_NFD, A_FETCH);
      A_DEC:     ucode = pk('0, 1'b0, 1'b0, 1'b0, SQ_DISP, C_NEVER, 0);
      A_NOP:     ucode = pk('0, 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      A_LDA:     ucode = pk(cb(B_PC_INC) | cb(B_MDR_LD), 1'b1, 1'b1, 1'b0, SQ_COND, C_NFD, A_LDA);
      A_LDA + 1: ucode = pk(cb(B_A_LD), 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      A_ADD:     ucode = pk(cb(B_ALU_ADD), 1'b0, 1'b0, 1'b0, SQ_INC, C_NEVER, 0);
      A_ADD + 1: ucode = pk(cb(B_A_LD) | cb(B_F_LD), 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      A_STA:     ucode = pk(cb(B_MAR_LD), 1'b0, 1'b0, 1'b0, SQ_INC, C_NEVER, 0);
      A_STA + 1: ucode = pk('0, 1'b1, 1'b0, 1'b1, SQ_FETCH, C_NEVER, 0);
      A_JZ:      ucode = pk('0, 1'b0, 1'b0, 1'b0, SQ_COND, C_Z, A_JZ + 2);
      A_JZ + 1:  ucode = pk(cb(B_PC_SKIP), 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      A_JZ + 2:  ucode = pk(cb(B_PC_LD), 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      A_TRAP:    ucode = pk(cb(B_TRAP), 1'b0, 1'b0, 1'b0, SQ_INC, C_NEVER, 0);
      A_TRAP + 1: ucode = pk(cb(B_PC_LD), 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
      default:   ucode = pk('0, 1'b0, 1'b0, 1'b0, SQ_FETCH, C_NEVER, 0);
    endcase
  endfunction

  function automatic logic [UA_W-1:0] jentry(input int op);
    case (op)
      'h00:    jentry = UA_W'(A_NOP);
      'h10:    jentry = UA_W'(A_LDA);
      'h20:    jentry = UA_W'(A_ADD);
      'h30:    jentry = UA_W'(A_STA);
      'h40:    jentry = UA_W'(A_JZ);
      default: jentry = UA_W'(A_TRAP);
    endcase
  endfunction

  logic [MW_W-1:0] urom [UDEPTH];
  logic [UA_W-1:0] jrom [JDEPTH];

  for (genvar i = 0; i < UDEPTH; i++) begin : g_urom
    assign urom[i] = ucode(i);
  end
  for (genvar j = 0; j < JDEPTH; j++) begin : g_jrom
    assign jrom[j] = jentry(j);
  end

  logic [UA_W-1:0] upc, upc_nx, tgt;
  logic [OP_W-1:0] ir;
  logic [MW_W-1:0] mw;
  logic [1:0]      seq;
  logic [2:0]      csel;
  logic [7:0]      cond_src;

  assign mw = urom[upc];
  assign {ctrl, mreq, rd, wr, seq, csel, tgt} = mw;

  for (genvar k = 0; k < 4; k++) begin : g_flag
    if (k < FL_W) begin : g_use
      assign cond_src[k] = flags[k];
    end else begin : g_tie
      assign cond_src[k] = 1'b0;
    end
  end
  assign cond_src[7:4] = {1'b0, 1'b1, ~fetch_done, fetch_done};

  always_comb begin
    case (seq)
      SQ_INC:   upc_nx = upc + 1'b1;
      SQ_DISP:  upc_nx = jrom[ir];
      SQ_FETCH: upc_nx = UA_W'(A_FETCH);
      default:  upc_nx = cond_src[csel] ? tgt : upc + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc <= UA_W'(A_FETCH);
      ir  <= '0;
    end else begin
      upc <= upc_nx;
      if (ctrl[B_IR_LD] && fetch_done) ir <= opcode;
    end
  end
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int OP_W = 8,
  parameter int CW_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_done,
  input logic [CW_W-1:0] ctrl,
  input logic            mreq,
  input logic            rd,
  input logic            wr,
  input logic [OP_W-1:0] ir,
  input logic [1:0]      seq
);
  logic ir_known;
  assign ir_known = (ir == OP_W'('h00)) || (ir == OP_W'('h10)) || (ir == OP_W'('h20)) ||
                    (ir == OP_W'('h30)) || (ir == OP_W'('h40));

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl == CW_W'('h5) && mreq && rd && !wr));

  p_fetch_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl == CW_W'('h5) && mreq && rd && !fetch_done) |=> (ctrl == CW_W'('h5) && mreq && rd));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl == CW_W'('h5) && mreq && rd && fetch_done) |=> (ctrl == '0 && !mreq && !rd && !wr));

  p_ir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[2] && fetch_done) |=> $stable(ir));

  p_trap_r10: assert property (@(posedge clk) disable iff (rst)
    (seq == 2'd1 && !ir_known) |=> (ctrl == CW_W'('h200)));

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst) !(rd && wr));

  p_strobe_mreq_r11: assert property (@(posedge clk) disable iff (rst) (rd || wr) |-> mreq);
endmodule

bind useq_ctrl useq_ctrl_chk #(.OP_W(OP_W), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_done(fetch_done), .ctrl(ctrl), .mreq(mreq),
  .rd(rd), .wr(wr), .ir(ir), .seq(seq)
);

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = '0;
  logic        fetch_done = 1'b0;
  logic [3:0]  flags = '0;
  logic [15:0] ctrl;
  logic        mreq, rd, wr;

  int tests = 0;
  int fails = 0;

  logic [18:0] q_exp [$];
  string       q_tag [$];

  localparam logic [15:0] W_FETCH = 16'h0005, W_ZERO = 16'h0000;

  always #2 clk = ~clk;

  useq_ctrl dut (
    .clk(clk), .rst(rst), .opcode(opcode), .fetch_done(fetch_done), .flags(flags),
    .ctrl(ctrl), .mreq(mreq), .rd(rd), .wr(wr)
  );

  task automatic cyc(input logic [7:0] op, input logic fd, input logic [3:0] fl,
                     input logic [15:0] ecw, input logic em, input logic er, input logic ew,
                     input string tag);
    @(negedge clk);
    opcode = op;
    fetch_done = fd;
    flags = fl;
    q_exp.push_back({ecw, em, er, ew});
    q_tag.push_back(tag);
  endtask

  task automatic fetch_decode(input logic [7:0] op, input string tag);
    cyc(op, 1'b1, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, {tag, " fetch (R2)"});
    cyc(8'hA5, 1'b0, 4'h0, W_ZERO, 1'b0, 1'b0, 1'b0, {tag, " decode (R2 R3)"});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [18:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        tests++;
        if ({ctrl, mreq, rd, wr} !== e) begin
          fails++;
          $display("FAIL %s: got ctrl=%h m/r/w=%b%b%b exp ctrl=%h m/r/w=%b", t,
                   ctrl, mreq, rd, wr, e[18:3], e[2:0]);
        end
        tests++;
        if ((rd && wr) || ((rd || wr) && !mreq)) begin
          fails++;
          $display("FAIL R11 strobes: got m/r/w=%b%b%b exp rd,wr exclusive under mreq", mreq, rd, wr);
        end
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    cyc(8'h00, 1'b0, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, "R1 reset state");
    rst = 1'b0;
    cyc(8'h20, 1'b0, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, "R1 first cycle after reset");
    cyc(8'h20, 1'b0, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, "R2 R5 fetch wait");
    cyc(8'h20, 1'b1, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, "R2 fetch capture");
    cyc(8'hFF, 1'b1, 4'h0, W_ZERO, 1'b0, 1'b0, 1'b0, "R3 decode with opcode changed");
    cyc(8'hFF, 1'b0, 4'h0, 16'h0080, 1'b0, 1'b0, 1'b0, "R6 R3 ADD step 1");
    cyc(8'hFF, 1'b0, 4'h0, 16'h0060, 1'b0, 1'b0, 1'b0, "R6 ADD step 2");

    fetch_decode(8'h10, "R4 LDA");
    cyc(8'h00, 1'b0, 4'h0, 16'h0011, 1'b1, 1'b1, 1'b0, "R7 R5 LDA operand wait");
    cyc(8'h00, 1'b0, 4'h0, 16'h0011, 1'b1, 1'b1, 1'b0, "R7 LDA operand wait");
    cyc(8'h00, 1'b1, 4'h0, 16'h0011, 1'b1, 1'b1, 1'b0, "R7 LDA operand done");
    cyc(8'h00, 1'b0, 4'h0, 16'h0020, 1'b0, 1'b0, 1'b0, "R7 LDA load A");

    fetch_decode(8'h30, "R4 STA");
    cyc(8'h00, 1'b0, 4'h0, 16'h0008, 1'b0, 1'b0, 1'b0, "R8 STA address");
    cyc(8'h00, 1'b0, 4'h0, W_ZERO, 1'b1, 1'b0, 1'b1, "R8 STA write");

    fetch_decode(8'h40, "R4 JZ taken");
    cyc(8'h00, 1'b0, 4'h1, W_ZERO, 1'b0, 1'b0, 1'b0, "R9 JZ test, zero set");
    cyc(8'h00, 1'b0, 4'h0, 16'h0002, 1'b0, 1'b0, 1'b0, "R9 JZ taken");

    fetch_decode(8'h40, "R4 JZ not taken");
    cyc(8'h00, 1'b0, 4'hE, W_ZERO, 1'b0, 1'b0, 1'b0, "R9 JZ test, zero clear");
    cyc(8'h00, 1'b0, 4'h0, 16'h0100, 1'b0, 1'b0, 1'b0, "R9 JZ not taken");

    fetch_decode(8'h00, "R4 NOP");
    cyc(8'h00, 1'b0, 4'h0, W_ZERO, 1'b0, 1'b0, 1'b0, "R4 NOP word");

    fetch_decode(8'h55, "R10 undefined 0x55");
    cyc(8'h00, 1'b0, 4'h0, 16'h0200, 1'b0, 1'b0, 1'b0, "R10 trap step 1");
    cyc(8'h00, 1'b0, 4'h0, 16'h0002, 1'b0, 1'b0, 1'b0, "R10 trap step 2");

    fetch_decode(8'hFF, "R10 undefined 0xFF");
    cyc(8'h00, 1'b0, 4'h0, 16'h0200, 1'b0, 1'b0, 1'b0, "R10 trap 0xFF step 1");
    cyc(8'h00, 1'b0, 4'h0, 16'h0002, 1'b0, 1'b0, 1'b0, "R10 trap 0xFF step 2");
    cyc(8'h00, 1'b0, 4'h0, W_FETCH, 1'b1, 1'b1, 1'b0, "R10 R5 back to fetch");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule